// File: doc/BRIEF.md
# Two-bit resistive cell recall and store sequencer

This block is the control sequencer for a memory cell that keeps two bits as one of four resistance levels of a programmable element. The cell shares its storage nodes with an ordinary static latch. Three thresholds are available: the first reference alone gives the highest, the second reference alone gives the middle, and the two in parallel give the lowest. The sequencer picks which of them the element is compared against, steps through the discharge, precharge and latch-resolve sequence of one comparison, and reads back the resolved state of the second storage node as a one-bit comparator result. The node reads low when the element is at or above the selected threshold and high when it is below.

On power-up, a recall finds the two bits by a binary search. The first comparison, against the middle threshold, gives the upper bit. That bit is copied to a companion latch bit, and it also chooses the threshold for the second comparison, which gives the lower bit. Before power-down, a store takes the upper bit from the companion bit and the lower bit from the cell's own latch. It then uses the same comparison to decide whether the element needs a set pulse (lower resistance), a reset pulse (higher resistance) or no pulse. No separate verify step is made.

Top module: `mlc_seq`

## Requirements
- R1: During and after a synchronous reset, the block shows the following values: busy=0, done=0, latch_n=1, precharge=0, set_pulse=0, reset_pulse=0, pl_high=0, and all three select outputs at 0.
- R2: Each comparison has four steps in a fixed order. First, the nodes are held discharged (latch_n=1, precharge=0) for T_DISCH cycles. Next comes precharge=1 with latch_n=1 for T_PRE cycles. Then latch_n is held low for T_LATCH cycles. Finally there is one sample cycle, in which latch_n is still low.
- R3: The first recall comparison drives {sel_main, sel_ref_a, sel_ref_b}=3'b101, which is the middle threshold. The upper bit is 1 when node_s2 reads 0.
- R4: The second recall comparison drives 3'b111 (the lowest threshold) when the upper bit is 0, and 3'b110 (the highest threshold) when the upper bit is 1. The lower bit is 1 when node_s2 reads 0.
- R5: Between the two recall comparisons there is exactly one cycle with comp_wr_en=1, and in it comp_wr_bit carries the upper bit. That cycle comes before the second precharge.
- R6: The code maps to the element's resistance r as follows: 2'b00 for r below the lowest threshold, 2'b01 from the lowest up to the middle threshold, 2'b10 from the middle up to the highest threshold, and 2'b11 at or above the highest threshold. After a recall, code_out holds that code.
- R7: A store to code c in 00, 01 or 10 first compares against the upper bound of the window. The select index is c, where index 0 selects 3'b111, 1 selects 3'b101 and 2 selects 3'b110. If node_s2 reads 0, the block drives pl_high=1 and set_pulse=1 for T_SET cycles. A store to code 11 skips this step.
- R8: A store to code c in 01, 10 or 11 then compares against the lower bound of the window, whose select index is c-1. If node_s2 reads 1, the block drives pl_high=0 and reset_pulse=1 for T_RST cycles. A store to code 00 skips this step.
- R9: Each store step makes exactly one comparison, and no comparison is repeated after a pulse. After a store, the element lies inside the window of the target code for every pair of starting level and target code.
- R10: busy rises only in the cycle after a request. done is high for one cycle, and busy falls in the next cycle. Requests that arrive while busy is high are ignored. When both requests arrive in the same idle cycle, the block performs a recall.
- R11: set_pulse and reset_pulse are never high together. Whenever either one is high, sel_main is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_recall | input | 1 | Recall request, taken while idle |
| start_store | input | 1 | Store request, taken while idle |
| comp_hi_in | input | 1 | Upper bit to store, read from the companion latch |
| cell_lo_in | input | 1 | Lower bit to store, read from the cell's own latch |
| node_s2 | input | 1 | Resolved second storage node: 1 means the element is below the threshold |
| sel_main | output | 1 | Connects the programmable element |
| sel_ref_a | output | 1 | Connects reference A |
| sel_ref_b | output | 1 | Connects reference B |
| latch_n | output | 1 | Active-low latch enable |
| precharge | output | 1 | Precharge / recall strobe |
| pl_high | output | 1 | Program-line level: 1 is the set level, 0 is low |
| set_pulse | output | 1 | Set pulse request |
| reset_pulse | output | 1 | Reset pulse request |
| comp_wr_en | output | 1 | Write strobe to the companion latch bit |
| comp_wr_bit | output | 1 | Recalled upper bit for the companion latch |
| code_out | output | 2 | Last recalled two-bit code |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion marker |

## Verification
Two request paths can land in the same cycle. The first case is a recall and a store requested together while idle. The bench raises both strobes on one edge, with a starting level whose store would need a pulse. It then judges the outcome by the absence of any pulse, the unchanged modelled resistance and the recalled code. The second case is a store request arriving during a recall. The bench raises it mid-sequence and checks that only two comparisons and no pulse occur, and that busy stays low afterwards. The behavioural cell model resolves node_s2 from the selected threshold. It moves the resistance when a pulse starts, so a wrong select value or a wrong pulse shows up as a window miss.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DISCH,
        ST_PRECH,
        ST_LATCH,
        ST_SAMPLE,
        ST_COPY,
        ST_PULSE,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_RC1,
        PH_RC2,
        PH_ST1,
        PH_ST2
    } phase_e;

    typedef struct packed {
        logic main;
        logic ref_a;
        logic ref_b;
    } refsel_t;

    localparam logic [1:0] THR_LOW  = 2'd0;
    localparam logic [1:0] THR_MID  = 2'd1;
    localparam logic [1:0] THR_HIGH = 2'd2;

    function automatic refsel_t thr_to_sel(input logic [1:0] idx);
        refsel_t s;
        case (idx)
            THR_LOW: s = '{main: 1'b1, ref_a: 1'b1, ref_b: 1'b1};
            THR_MID: s = '{main: 1'b1, ref_a: 1'b0, ref_b: 1'b1};
            default: s = '{main: 1'b1, ref_a: 1'b1, ref_b: 1'b0};
        endcase
        return s;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mlc_timer.sv
module mlc_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/mlc_refsel.sv
module mlc_refsel
    import mlc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  phase_e        phase,
    input  logic          hi_bit,
    input  logic [1:0]    target,
    output refsel_t       sel
);
    always_comb begin
        sel = '0;
        if (active) begin
            case (phase)
                PH_RC1:  sel = thr_to_sel(THR_MID);
                PH_RC2:  sel = thr_to_sel(hi_bit ? THR_HIGH : THR_LOW);
                PH_ST1:  sel = thr_to_sel(target);
                default: sel = thr_to_sel(target - 2'd1);
            endcase
        end
    end

    // R3: first recall comparison always against the middle threshold
    a_r3_first_mid: assert property (@(posedge clk) disable iff (rst)
        (active && phase == PH_RC1) |-> (sel.main && !sel.ref_a && sel.ref_b));

    // R4: second recall comparison always has both the element and reference A on
    a_r4_second_refa: assert property (@(posedge clk) disable iff (rst)
        (active && phase == PH_RC2) |-> (sel.main && sel.ref_a));

endmodule

// File: rtl/mlc_seq.sv
module mlc_seq
    import mlc_pkg::*;
#(
    parameter int T_DISCH = 2,
    parameter int T_PRE   = 3,
    parameter int T_LATCH = 2,
    parameter int T_SET   = 4,
    parameter int T_RST   = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_recall,
    input  logic       start_store,
    input  logic       comp_hi_in,
    input  logic       cell_lo_in,
    input  logic       node_s2,
    output logic       sel_main,
    output logic       sel_ref_a,
    output logic       sel_ref_b,
    output logic       latch_n,
    output logic       precharge,
    output logic       pl_high,
    output logic       set_pulse,
    output logic       reset_pulse,
    output logic       comp_wr_en,
    output logic       comp_wr_bit,
    output logic [1:0] code_out,
    output logic       busy,
    output logic       done
);
    localparam int TMAX = imax(imax(imax(T_DISCH, T_PRE), imax(T_LATCH, T_SET)), T_RST);
    localparam int TW   = $clog2(TMAX + 1);

    seq_state_e state_q, state_d;
    phase_e     phase_q, phase_d;
    logic       hi_q, hi_d, lo_q, lo_d;
    logic [1:0] target_q, target_d;
    logic       pset_q, pset_d;
    logic       t_load, t_zero;
    logic [TW-1:0] t_val;
    logic       sel_active;
    refsel_t    sel;

    always_comb begin
        state_d  = state_q;
        phase_d  = phase_q;
        hi_d     = hi_q;
        lo_d     = lo_q;
        target_d = target_q;
        pset_d   = pset_q;
        case (state_q)
            ST_IDLE: begin
                if (start_recall) begin
                    phase_d = PH_RC1;
                    state_d = ST_DISCH;
                end else if (start_store) begin
                    target_d = {comp_hi_in, cell_lo_in};
                    phase_d  = ({comp_hi_in, cell_lo_in} == 2'b11) ? PH_ST2 : PH_ST1;
                    state_d  = ST_DISCH;
                end
            end
            ST_DISCH: if (t_zero) state_d = ST_PRECH;
            ST_PRECH: if (t_zero) state_d = ST_LATCH;
            ST_LATCH: if (t_zero) state_d = ST_SAMPLE;
            ST_SAMPLE: begin
                case (phase_q)
                    PH_RC1: begin
                        hi_d    = !node_s2;
                        state_d = ST_COPY;
                    end
                    PH_RC2: begin
                        lo_d    = !node_s2;
                        state_d = ST_DONE;
                    end
                    PH_ST1: begin
                        if (!node_s2) begin
                            pset_d  = 1'b1;
                            state_d = ST_PULSE;
                        end else if (target_q != 2'b00) begin
                            phase_d = PH_ST2;
                            state_d = ST_DISCH;
                        end else begin
                            state_d = ST_DONE;
                        end
                    end
                    default: begin
                        if (node_s2) begin
                            pset_d  = 1'b0;
                            state_d = ST_PULSE;
                        end else begin
                            state_d = ST_DONE;
                        end
                    end
                endcase
            end
            ST_COPY: begin
                phase_d = PH_RC2;
                state_d = ST_DISCH;
            end
            ST_PULSE: begin
                if (t_zero) begin
                    if (phase_q == PH_ST1 && target_q != 2'b00) begin
                        phase_d = PH_ST2;
                        state_d = ST_DISCH;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        t_load = (state_d != state_q);
        case (state_d)
            ST_DISCH: t_val = TW'(T_DISCH - 1);
            ST_PRECH: t_val = TW'(T_PRE - 1);
            ST_LATCH: t_val = TW'(T_LATCH - 1);
            ST_PULSE: t_val = pset_d ? TW'(T_SET - 1) : TW'(T_RST - 1);
            default:  t_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            phase_q  <= PH_RC1;
            hi_q     <= 1'b0;
            lo_q     <= 1'b0;
            target_q <= 2'b00;
            pset_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            phase_q  <= phase_d;
            hi_q     <= hi_d;
            lo_q     <= lo_d;
            target_q <= target_d;
            pset_q   <= pset_d;
        end
    end

    mlc_timer #(.W(TW)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    assign sel_active = (state_q == ST_DISCH) || (state_q == ST_PRECH) ||
                        (state_q == ST_LATCH) || (state_q == ST_SAMPLE) ||
                        (state_q == ST_PULSE);

    mlc_refsel i_refsel (
        .clk    (clk),
        .rst    (rst),
        .active (sel_active),
        .phase  (phase_q),
        .hi_bit (hi_q),
        .target (target_q),
        .sel    (sel)
    );

    assign sel_main    = sel.main;
    assign sel_ref_a   = sel.ref_a;
    assign sel_ref_b   = sel.ref_b;
    assign latch_n     = !((state_q == ST_LATCH) || (state_q == ST_SAMPLE) || (state_q == ST_PULSE));
    assign precharge   = (state_q == ST_PRECH);
    assign set_pulse   = (state_q == ST_PULSE) && pset_q;
    assign reset_pulse = (state_q == ST_PULSE) && !pset_q;
    assign pl_high     = set_pulse;
    assign comp_wr_en  = (state_q == ST_COPY);
    assign comp_wr_bit = hi_q;
    assign code_out    = {hi_q, lo_q};
    assign busy        = (state_q != ST_IDLE);
    assign done        = (state_q == ST_DONE);

    // R11: never both pulse kinds at once
    a_r11_pulse_excl: assert property (@(posedge clk) disable iff (rst)
        !(set_pulse && reset_pulse));

    // R7: set pulse only with program line at set level and element connected
    a_r7_set_level: assert property (@(posedge clk) disable iff (rst)
        set_pulse |-> (pl_high && sel_main));

    // R8: reset pulse only with program line low and element connected
    a_r8_reset_level: assert property (@(posedge clk) disable iff (rst)
        reset_pulse |-> (!pl_high && sel_main));

    // R2: precharge only while the latch is disabled
    a_r2_pre_latch_off: assert property (@(posedge clk) disable iff (rst)
        precharge |-> latch_n);

    // R2: latch enables only straight after precharge
    a_r2_latch_after_pre: assert property (@(posedge clk) disable iff (rst)
        $fell(latch_n) |-> $past(precharge));

    // R5: companion write happens with nodes released
    a_r5_copy_idle_nodes: assert property (@(posedge clk) disable iff (rst)
        comp_wr_en |-> (latch_n && !precharge && !sel_main));

    // R10: done is followed by idle
    a_r10_done_then_idle: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R10: busy starts only from a request
    a_r10_busy_from_req: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_recall || start_store));

endmodule

// File: tb/test_mlc_seq.sv
module test_mlc_seq;
    localparam int T_DISCH = 2;
    localparam int T_PRE   = 3;
    localparam int T_LATCH = 2;
    localparam int T_SET   = 4;
    localparam int T_RST   = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_recall = 1'b0, start_store = 1'b0;
    logic comp_hi_in = 1'b0, cell_lo_in = 1'b0;
    logic node_s2;
    logic sel_main, sel_ref_a, sel_ref_b, latch_n, precharge, pl_high;
    logic set_pulse, reset_pulse, comp_wr_en, comp_wr_bit, busy, done;
    logic [1:0] code_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    mlc_seq #(.T_DISCH(T_DISCH), .T_PRE(T_PRE), .T_LATCH(T_LATCH),
              .T_SET(T_SET), .T_RST(T_RST)) i_mlc_seq (
        .clk(clk), .rst(rst), .start_recall(start_recall), .start_store(start_store),
        .comp_hi_in(comp_hi_in), .cell_lo_in(cell_lo_in), .node_s2(node_s2),
        .sel_main(sel_main), .sel_ref_a(sel_ref_a), .sel_ref_b(sel_ref_b),
        .latch_n(latch_n), .precharge(precharge), .pl_high(pl_high),
        .set_pulse(set_pulse), .reset_pulse(reset_pulse),
        .comp_wr_en(comp_wr_en), .comp_wr_bit(comp_wr_bit),
        .code_out(code_out), .busy(busy), .done(done));

    // thresholds in kilo-ohm: lowest 39, middle 65, highest 100
    function automatic int thr(input logic a, input logic b);
        if (a && b) return 39;
        if (!a && b) return 65;
        if (a && !b) return 100;
        return 0;
    endfunction

    function automatic logic [2:0] esel(input int idx);
        if (idx == 0) return 3'b111;
        if (idx == 1) return 3'b101;
        return 3'b110;
    endfunction

    function automatic int level_r(input int code);
        if (code == 0) return 20;
        if (code == 1) return 50;
        if (code == 2) return 80;
        return 130;
    endfunction

    // behavioural cell and monitor
    int res = 50;
    int res_init = 50;
    logic res_load = 1'b0;
    int pre_cnt, set_cnt, rst_cnt, wr_cnt, wr_at_pre;
    int set_run, rst_run, set_w, rst_w, pre_run, pre_w, dis_run, dis_w, lat_run, lat_w;
    int bad_pulse;
    logic comp_reg;
    logic pre_d, set_d, rst_d, lat_d;
    logic [2:0] sel_log [4];

    assign node_s2 = !latch_n && sel_main && (res < thr(sel_ref_a, sel_ref_b));

    initial begin
        pre_d = 0; set_d = 0; rst_d = 0; lat_d = 1; comp_reg = 0; bad_pulse = 0;
        pre_cnt = 0; set_cnt = 0; rst_cnt = 0; wr_cnt = 0; wr_at_pre = 0;
        set_run = 0; rst_run = 0; set_w = 0; rst_w = 0; pre_run = 0; pre_w = 0;
        dis_run = 0; dis_w = 0; lat_run = 0; lat_w = 0;
        for (int k = 0; k < 4; k++) sel_log[k] = 3'b000;
    end

    always @(negedge clk) begin
        cycles++;
        if (res_load) begin
            res = res_init;
            pre_cnt = 0; set_cnt = 0; rst_cnt = 0; wr_cnt = 0; wr_at_pre = 0;
            set_w = 0; rst_w = 0; pre_w = 0; dis_w = 0; lat_w = 0;
        end
        if (precharge && !pre_d) begin
            if (pre_cnt < 4) sel_log[pre_cnt] = {sel_main, sel_ref_a, sel_ref_b};
            pre_cnt++;
            dis_w = dis_run;
        end
        if (busy && latch_n && !precharge && !comp_wr_en && !done) dis_run++;
        else dis_run = 0;
        if (precharge) pre_run++;
        else if (pre_d) begin pre_w = pre_run; pre_run = 0; end
        if (!latch_n) lat_run++;
        else if (!lat_d) begin lat_w = lat_run; lat_run = 0; end
        if (set_pulse && !set_d) begin set_cnt++; res = thr(sel_ref_a, sel_ref_b) - 5; end
        if (reset_pulse && !rst_d) begin rst_cnt++; res = thr(sel_ref_a, sel_ref_b) + 5; end
        if (set_pulse) set_run++;
        else if (set_d) begin set_w = set_run; set_run = 0; end
        if (reset_pulse) rst_run++;
        else if (rst_d) begin rst_w = rst_run; rst_run = 0; end
        if ((set_pulse && reset_pulse) || (set_pulse && !pl_high) ||
            (reset_pulse && pl_high) || ((set_pulse || reset_pulse) && !sel_main))
            bad_pulse++;
        if (comp_wr_en) begin comp_reg = comp_wr_bit; wr_cnt++; wr_at_pre = pre_cnt; end
        pre_d = precharge; set_d = set_pulse; rst_d = reset_pulse; lat_d = latch_n;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic prep(input int r);
        res_init = r;
        res_load = 1'b1;
        @(negedge clk);
        @(posedge clk);
        res_load = 1'b0;
        @(negedge clk);
    endtask

    // mode: 0 recall, 1 store, 2 both at once
    task automatic run_op(input int mode, input int tgt);
        int n;
        comp_hi_in = tgt[1];
        cell_lo_in = tgt[0];
        start_recall = (mode != 1);
        start_store  = (mode != 0);
        @(negedge clk);
        start_recall = 1'b0;
        start_store  = 1'b0;
        n = 0;
        while (!done && n < 500) begin @(negedge clk); n++; end
        chk(done === 1'b1, "R10 done reached", n, 0);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R10 done one cycle then idle", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 0 && done === 0 && latch_n === 1 && precharge === 0, "R1 reset ctrl",
            int'({busy, done, latch_n, precharge}), 2);
        chk(set_pulse === 0 && reset_pulse === 0 && pl_high === 0 &&
            {sel_main, sel_ref_a, sel_ref_b} === 3'b000, "R1 reset pulses/selects",
            int'({set_pulse, reset_pulse, pl_high, sel_main, sel_ref_a, sel_ref_b}), 0);
        rst = 1'b0;
        @(negedge clk);

        // recall of every level
        for (int c = 0; c < 4; c++) begin
            prep(level_r(c));
            run_op(0, 0);
            chk(code_out === c[1:0], "R6 recall code", int'(code_out), c);
            chk(pre_cnt == 2, "R2 two comparisons", pre_cnt, 2);
            chk(sel_log[0] == 3'b101, "R3 first select", int'(sel_log[0]), 5);
            chk(sel_log[1] == (c[1] ? 3'b110 : 3'b111), "R4 second select",
                int'(sel_log[1]), c[1] ? 6 : 7);
            chk(wr_cnt == 1 && wr_at_pre == 1 && comp_reg == c[1], "R5 companion copy",
                int'(comp_reg), c[1]);
            chk(dis_w == T_DISCH && pre_w == T_PRE && lat_w == T_LATCH + 1, "R2 step lengths",
                dis_w * 100 + pre_w * 10 + lat_w, T_DISCH * 100 + T_PRE * 10 + T_LATCH + 1);
            chk(set_cnt == 0 && rst_cnt == 0, "R11 recall makes no pulse", set_cnt + rst_cnt, 0);
        end

        // store: every starting level against every target code
        for (int l = 0; l < 4; l++) begin
            for (int t = 0; t < 4; t++) begin
                int lo_b, hi_b, steps;
                prep(level_r(l));
                run_op(1, t);
                lo_b  = (t == 0) ? 0 : (t == 1) ? 39 : (t == 2) ? 65 : 100;
                hi_b  = (t == 0) ? 39 : (t == 1) ? 65 : (t == 2) ? 100 : 100000;
                steps = (t == 0 || t == 3) ? 1 : 2;
                chk(set_cnt == ((l > t) ? 1 : 0), "R7 set pulse count", set_cnt, (l > t) ? 1 : 0);
                chk(rst_cnt == ((l < t) ? 1 : 0), "R8 reset pulse count", rst_cnt, (l < t) ? 1 : 0);
                if (l > t) chk(set_w == T_SET, "R7 set width", set_w, T_SET);
                if (l < t) chk(rst_w == T_RST, "R8 reset width", rst_w, T_RST);
                chk(pre_cnt == steps, "R9 one comparison per step", pre_cnt, steps);
                chk(sel_log[0] == ((t == 3) ? esel(2) : esel(t)), "R7 first store select",
                    int'(sel_log[0]), int'((t == 3) ? esel(2) : esel(t)));
                if (steps == 2)
                    chk(sel_log[1] == esel(t - 1), "R8 lower bound select",
                        int'(sel_log[1]), int'(esel(t - 1)));
                chk(res >= lo_b && res < hi_b, "R9 element in window", res, lo_b);
                run_op(0, 0);
                chk(code_out === t[1:0], "R9 recall after store", int'(code_out), t);
            end
        end

        // both requests in one idle cycle: recall wins, no pulse
        prep(80);
        run_op(2, 0);
        chk(set_cnt == 0 && rst_cnt == 0 && res == 80, "R10 both requests -> recall", res, 80);
        chk(code_out === 2'b10, "R10 recall result on clash", int'(code_out), 2);

        // store request during a recall is ignored
        prep(130);
        start_recall = 1'b1;
        @(negedge clk);
        start_recall = 1'b0;
        repeat (4) @(negedge clk);
        comp_hi_in = 1'b0; cell_lo_in = 1'b0;
        start_store = 1'b1;
        @(negedge clk);
        start_store = 1'b0;
        while (!done) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(busy === 1'b0, "R10 busy-time request ignored", int'(busy), 0);
        chk(pre_cnt == 2 && set_cnt == 0 && res == 130, "R10 no extra sequence", pre_cnt, 2);
        chk(code_out === 2'b11, "R6 highest level code", int'(code_out), 3);

        chk(bad_pulse == 0, "R11 pulse/level/select relation", bad_pulse, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        checks++;
        $display("FAIL R10 watchdog actual=%0d expected=0", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule